// File: doc/BRIEF.md
# Four-Channel Thermal Monitor Register Target

This block is the register file and transaction sequencer of a four-channel temperature monitor. It sits behind a byte-level serial target engine, which hands it three bus-event strobes (write-start, read-start, stop), each received byte with a valid strobe, and a request for each byte to transmit. The block holds one 8-bit reading per channel, a high and a low limit per channel, and three fixed identification bytes. A side-band load port stands in for the sensing front end and places whole-degree readings into the temperature registers.

A host addresses a register by opening a write and sending the register address as the first byte. A second byte in the same write updates that register if it is a limit. To read, the host sets the address the same way, issues a repeated start for reading, and takes the first byte. The register address never advances on its own, so every byte after the first in a read is padding.

Top module: `thermo_reg_target`

## Requirements
- R1: On reset all four readings and all four low limits are 0x00, all four high limits are 0x55, the register pointer is 0x00 and the byte counter is at its first position, so `tx_data` shows 0x00 before any read.
- R2: In a write, the first received byte loads the register pointer and the second received byte is stored in the register the pointer selects, if that register is writable.
- R3: Received bytes after the second one in a write are discarded, and the pointer keeps its value.
- R4: A read-start copies the register the pointer selects into a holding byte, and the first transmitted byte of the read is that value.
- R5: Every transmitted byte after the first in the same read is 0xFF.
- R6: Any of the three bus events returns the byte counter to its first position, so the next received byte is again taken as a pointer and the next transmitted byte again carries the holding byte.
- R7: The readings of channels 0, 1, 2, 3 sit at addresses 0x00, 0x01, 0x23, 0x2A and bus writes to them are discarded.
- R8: The high/low limit pairs sit at 0x05/0x06 (channel 0), 0x07/0x08 (channel 1), 0x15/0x16 (channel 2) and 0x2C/0x2D (channel 3); these eight are the only bus-writable addresses.
- R9: Address 0xFD returns the device code (0x21 by default, 0x25 when `ALT_VARIANT` is 1), 0xFE returns 0x5D and 0xFF returns 0x04; writes to them are discarded.
- R10: A read-start with the pointer on an unmapped address leaves the holding byte unchanged, so the previously captured value is transmitted again; writes to unmapped addresses are discarded.
- R11: A load strobe with a 2-bit channel index and an 8-bit value writes that channel's reading at the next clock edge.
- R12: A load and a bus limit write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_wr_start | input | 1 | Start (or repeated start) of a write transfer |
| ev_rd_start | input | 1 | Start (or repeated start) of a read transfer |
| ev_stop | input | 1 | Stop condition |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | The engine consumes `tx_data` at this clock edge |
| tx_data | output | 8 | Byte to transmit; valid while `tx_req` is high |
| ld_en | input | 1 | Side-band temperature load strobe |
| ld_chan | input | 2 | Channel selected by the load |
| ld_temp | input | 8 | Whole-degree reading to load |

## Verification
The assertions take for granted that the bus engine raises at most one of the three event strobes per cycle, never raises `rx_valid` or `tx_req` in the same cycle as an event, and raises `tx_req` only inside a read. The stimulus keeps to this by driving each event, byte and transmit request as its own one-cycle pulse; the only deliberate overlap is a received byte together with a side-band load, which the interface allows. Under these conditions the properties on pointer hold, counter clearing, padding bytes and register stability cover the rules that the directed reads observe only at chosen points.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int DW   = 8;
    localparam int NCH  = 4;
    localparam int CH_W = $clog2(NCH);

    localparam logic [DW-1:0] HI_RST  = 8'h55;
    localparam logic [DW-1:0] LO_RST  = 8'h00;
    localparam logic [DW-1:0] TMP_RST = 8'h00;
    localparam logic [DW-1:0] FILL    = 8'hFF;

    localparam logic [DW-1:0] DEVID_BASE = 8'h21;
    localparam logic [DW-1:0] DEVID_ALT  = 8'h25;
    localparam logic [DW-1:0] MFR_CODE   = 8'h5D;
    localparam logic [DW-1:0] REV_CODE   = 8'h04;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_TEMP,
        RK_HI,
        RK_LO,
        RK_DEVID,
        RK_MFR,
        RK_REV
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [CH_W-1:0]   ch;
    } reg_sel_t;

    typedef enum logic [1:0] {
        BC_FIRST,
        BC_SECOND,
        BC_DONE
    } byte_pos_e;

    function automatic reg_sel_t sel_make(reg_kind_e k, int c);
        reg_sel_t s;
        s.kind = k;
        s.ch   = CH_W'(c);
        return s;
    endfunction

    // Sparse address map; channel order of each group is fixed by the bus map.
    function automatic reg_sel_t map_addr(logic [DW-1:0] a);
        reg_sel_t s;
        case (a)
            8'h00:   s = sel_make(RK_TEMP, 0);
            8'h01:   s = sel_make(RK_TEMP, 1);
            8'h23:   s = sel_make(RK_TEMP, 2);
            8'h2A:   s = sel_make(RK_TEMP, 3);
            8'h05:   s = sel_make(RK_HI, 0);
            8'h06:   s = sel_make(RK_LO, 0);
            8'h07:   s = sel_make(RK_HI, 1);
            8'h08:   s = sel_make(RK_LO, 1);
            8'h15:   s = sel_make(RK_HI, 2);
            8'h16:   s = sel_make(RK_LO, 2);
            8'h2C:   s = sel_make(RK_HI, 3);
            8'h2D:   s = sel_make(RK_LO, 3);
            8'hFD:   s = sel_make(RK_DEVID, 0);
            8'hFE:   s = sel_make(RK_MFR, 0);
            8'hFF:   s = sel_make(RK_REV, 0);
            default: s = sel_make(RK_NONE, 0);
        endcase
        return s;
    endfunction

    function automatic logic sel_writable(reg_sel_t s);
        return (s.kind == RK_HI) || (s.kind == RK_LO);
    endfunction

endpackage

// File: rtl/tsr_xact.sv
module tsr_xact
    import tsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_wr_start,
    input  logic          ev_rd_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          tx_req,
    input  logic          rd_hit,
    input  logic [DW-1:0] rd_val,
    output logic [DW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] hold,
    output logic          at_first
);

    byte_pos_e pos_q;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] hold_q;
    logic any_ev;

    assign any_ev   = ev_wr_start | ev_rd_start | ev_stop;
    assign ptr      = ptr_q;
    assign hold     = hold_q;
    assign at_first = (pos_q == BC_FIRST);
    assign wr_en    = rx_valid && !any_ev && (pos_q == BC_SECOND);
    assign wr_data  = rx_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= BC_FIRST;
            ptr_q  <= '0;
            hold_q <= '0;
        end else if (any_ev) begin
            pos_q <= BC_FIRST;
            if (ev_rd_start && rd_hit) begin
                hold_q <= rd_val;
            end
        end else if (rx_valid) begin
            case (pos_q)
                BC_FIRST: begin
                    ptr_q <= rx_data;
                    pos_q <= BC_SECOND;
                end
                BC_SECOND: pos_q <= BC_DONE;
                default:   pos_q <= BC_DONE;
            endcase
        end else if (tx_req) begin
            pos_q <= (pos_q == BC_FIRST) ? BC_SECOND : BC_DONE;
        end
    end

    // R6
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_wr_start || ev_rd_start || ev_stop) |=> at_first);

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!at_first && rx_valid && !any_ev) |=> $stable(ptr_q));

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_rd_start && !rd_hit) |=> $stable(hold_q));

    // R4
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_rd_start && rd_hit) |=> (hold_q == $past(rd_val)));

endmodule

// File: rtl/tsr_regbank.sv
module tsr_regbank
    import tsr_pkg::*;
#(
    parameter logic [DW-1:0] DEV_ID = DEVID_BASE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_sel_t        wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            ld_en,
    input  logic [CH_W-1:0] ld_chan,
    input  logic [DW-1:0]   ld_temp,
    input  reg_sel_t        rd_sel,
    output logic            rd_hit,
    output logic [DW-1:0]   rd_val
);

    logic [DW-1:0] temp_q [NCH];
    logic [DW-1:0] hi_q   [NCH];
    logic [DW-1:0] lo_q   [NCH];
    logic          wr_ok;

    assign wr_ok = wr_en && sel_writable(wr_sel);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic ld_here;
        logic wr_here;

        assign ld_here = ld_en && (ld_chan == CH_W'(g));
        assign wr_here = wr_ok && (wr_sel.ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                temp_q[g] <= TMP_RST;
                hi_q[g]   <= HI_RST;
                lo_q[g]   <= LO_RST;
            end else begin
                if (ld_here) begin
                    temp_q[g] <= ld_temp;
                end
                if (wr_here && wr_sel.kind == RK_HI) begin
                    hi_q[g] <= wr_data;
                end
                if (wr_here && wr_sel.kind == RK_LO) begin
                    lo_q[g] <= wr_data;
                end
            end
        end

        // R7
        temp_ro_chk: assert property (@(posedge clk) disable iff (rst)
            !(ld_en && ld_chan == CH_W'(g)) |=> $stable(temp_q[g]));

        // R11
        temp_ld_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_en && ld_chan == CH_W'(g)) |=> (temp_q[g] == $past(ld_temp)));

        // R8
        lim_guard_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> ($stable(hi_q[g]) && $stable(lo_q[g])));
    end

    always_comb begin
        rd_hit = 1'b1;
        rd_val = '0;
        case (rd_sel.kind)
            RK_TEMP:  rd_val = temp_q[rd_sel.ch];
            RK_HI:    rd_val = hi_q[rd_sel.ch];
            RK_LO:    rd_val = lo_q[rd_sel.ch];
            RK_DEVID: rd_val = DEV_ID;
            RK_MFR:   rd_val = MFR_CODE;
            RK_REV:   rd_val = REV_CODE;
            default:  rd_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/thermo_reg_target.sv
module thermo_reg_target
    import tsr_pkg::*;
#(
    parameter bit ALT_VARIANT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_wr_start,
    input  logic       ev_rd_start,
    input  logic       ev_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_req,
    output logic [7:0] tx_data,
    input  logic       ld_en,
    input  logic [1:0] ld_chan,
    input  logic [7:0] ld_temp
);

    localparam logic [DW-1:0] DEV_CODE = ALT_VARIANT ? DEVID_ALT : DEVID_BASE;

    logic [DW-1:0] ptr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] hold;
    logic          at_first;
    logic          rd_hit;
    logic [DW-1:0] rd_val;
    reg_sel_t      cur_sel;

    assign cur_sel = map_addr(ptr);

    tsr_xact i_xact (
        .clk         (clk),
        .rst         (rst),
        .ev_wr_start (ev_wr_start),
        .ev_rd_start (ev_rd_start),
        .ev_stop     (ev_stop),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_req      (tx_req),
        .rd_hit      (rd_hit),
        .rd_val      (rd_val),
        .ptr         (ptr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .hold        (hold),
        .at_first    (at_first)
    );

    tsr_regbank #(
        .DEV_ID (DEV_CODE)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (cur_sel),
        .wr_data (wr_data),
        .ld_en   (ld_en),
        .ld_chan (ld_chan),
        .ld_temp (ld_temp),
        .rd_sel  (cur_sel),
        .rd_hit  (rd_hit),
        .rd_val  (rd_val)
    );

    assign tx_data = at_first ? hold : FILL;

    // R5
    pad_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !ev_rd_start && !ev_wr_start && !ev_stop) |=> (tx_data == FILL));

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (tx_data == 8'h00));

endmodule

// File: tb/test_thermo_reg_target.sv
`timescale 1ns/1ps
module test_thermo_reg_target;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_wr_start = 1'b0;
    logic       ev_rd_start = 1'b0;
    logic       ev_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_req = 1'b0;
    logic [7:0] tx_data;
    logic       ld_en = 1'b0;
    logic [1:0] ld_chan = 2'd0;
    logic [7:0] ld_temp = 8'h00;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    thermo_reg_target i_thermo_reg_target (
        .clk         (clk),
        .rst         (rst),
        .ev_wr_start (ev_wr_start),
        .ev_rd_start (ev_rd_start),
        .ev_stop     (ev_stop),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_req      (tx_req),
        .tx_data     (tx_data),
        .ld_en       (ld_en),
        .ld_chan     (ld_chan),
        .ld_temp     (ld_temp)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h05, 8'h00, 8'h55, 8'd1},  // R1 high limit default
        '{1'b0, 8'h06, 8'h00, 8'h00, 8'd1},  // R1 low limit default
        '{1'b0, 8'h2C, 8'h00, 8'h55, 8'd1},  // R1
        '{1'b0, 8'hFD, 8'h00, 8'h21, 8'd9},  // R9 device code
        '{1'b0, 8'hFE, 8'h00, 8'h5D, 8'd9},  // R9
        '{1'b0, 8'hFF, 8'h00, 8'h04, 8'd9},  // R9
        '{1'b1, 8'h05, 8'h3C, 8'h3C, 8'd2},  // R2 / R8
        '{1'b1, 8'h08, 8'h11, 8'h11, 8'd8},  // R8
        '{1'b1, 8'h15, 8'h7F, 8'h7F, 8'd8},  // R8
        '{1'b1, 8'h2D, 8'h0A, 8'h0A, 8'd8},  // R8
        '{1'b1, 8'h00, 8'h99, 8'h00, 8'd7},  // R7 read-only reading
        '{1'b1, 8'h2A, 8'h99, 8'h00, 8'd7},  // R7
        '{1'b1, 8'hFE, 8'h00, 8'h5D, 8'd9}   // R9 read-only code
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic ev_w();
        ev_wr_start = 1'b1; cyc(); ev_wr_start = 1'b0;
    endtask

    task automatic ev_r();
        ev_rd_start = 1'b1; cyc(); ev_rd_start = 1'b0;
    endtask

    task automatic ev_s();
        ev_stop = 1'b1; cyc(); ev_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1; cyc(); rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        tx_req = 1'b1;
        #1;
        b = tx_data;
        cyc();
        tx_req = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        ev_w(); put(a); put(d); ev_s();
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        ev_w(); put(a); ev_r(); get(d); ev_s();
    endtask

    task automatic load(input logic [1:0] c, input logic [7:0] v);
        ld_en = 1'b1; ld_chan = c; ld_temp = v; cyc(); ld_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1: holding byte and counter after reset
        check(1, tx_data, 8'h00);
        rd_reg(8'h00, b); check(1, b, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr_reg(VECS[i].addr, VECS[i].data);
            rd_reg(VECS[i].addr, b);
            check(int'(VECS[i].req), b, VECS[i].exp);
        end

        // R3: extra bytes discarded, pointer stays put
        ev_w(); put(8'h06); put(8'h20); put(8'h44); put(8'h45); ev_s();
        ev_r(); get(b); ev_s();
        check(3, b, 8'h20);
        rd_reg(8'h07, b); check(3, b, 8'h55);

        // R4 / R5: first byte data, rest padding
        ev_w(); put(8'h05); ev_r();
        get(b); check(4, b, 8'h3C);
        get(b); check(5, b, 8'hFF);
        get(b); check(5, b, 8'hFF);
        // R6: repeated read-start rewinds the counter
        ev_r(); get(b); check(6, b, 8'h3C);
        ev_s();

        // R6: stop between pointer and data makes next byte a pointer
        ev_w(); put(8'h07); ev_s();
        ev_w(); put(8'h16); put(8'h33); ev_s();
        rd_reg(8'h16, b); check(6, b, 8'h33);
        rd_reg(8'h07, b); check(6, b, 8'h55);

        // R10: unmapped address keeps the last captured byte
        rd_reg(8'h05, b); check(10, b, 8'h3C);
        wr_reg(8'h40, 8'h12);
        rd_reg(8'h40, b); check(10, b, 8'h3C);
        rd_reg(8'h08, b); check(10, b, 8'h11);

        // R11: side-band loads per channel
        load(2'd2, 8'h4B);
        load(2'd3, 8'h1E);
        load(2'd0, 8'h2F);
        load(2'd1, 8'h1C);
        rd_reg(8'h23, b); check(11, b, 8'h4B);
        rd_reg(8'h2A, b); check(11, b, 8'h1E);
        rd_reg(8'h00, b); check(11, b, 8'h2F);
        rd_reg(8'h01, b); check(11, b, 8'h1C);

        // R12: load and bus limit write in one cycle
        ev_w(); put(8'h07);
        rx_data = 8'h40; rx_valid = 1'b1;
        ld_en = 1'b1; ld_chan = 2'd1; ld_temp = 8'h22;
        cyc();
        rx_valid = 1'b0; ld_en = 1'b0;
        ev_s();
        rd_reg(8'h07, b); check(12, b, 8'h40);
        rd_reg(8'h01, b); check(12, b, 8'h22);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule